// File: doc/BRIEF.md
# Narrow-Width-Aware SEC-DED Register File

This block is a 64-entry, 64-bit register file built to survive soft errors, including bursts that upset several neighbouring cells. Each stored word is split into sixteen 4-bit groups. Every group carries its own extended Hamming (8,4) code: single-error correction and double-error detection. The four check bits of each group are kept in a separate 64-bit check word. They are spread across that word so that neighbouring check cells belong to different groups. The data groups are also spread within each 32-bit half, so a short run of upset data cells touches many groups once each rather than one group many times.

When a written value fits in 32 bits, the block stores two copies of it. A value fits when its upper 32 bits all equal bit 31. The lower half and the upper half of the data word each hold one copy, and each copy is covered by its own eight codewords. A pair of duplicated format bits records whether the entry holds two half-width copies or one full word.

On a read, combinational logic decodes all sixteen codewords. For a half-width entry it picks the copy that survived, and it sign-extends that copy to 64 bits. It raises a correction flag when it repaired or bypassed damage. It raises an uncorrectable flag only when no good copy exists. Two read ports and one synchronous write port are provided. A fault-injection port XORs masks into the stored data, check and format bits, so that upsets can be produced on purpose.

Top module: `rfp_regfile`

## Requirements
- R1: After synchronous reset every entry reads as zero on both ports, with both flags low.
- R2: A write takes effect at the clock edge; reads are combinational and independent on the two ports. A read of the entry being written in the same cycle returns the previous contents.
- R3: A written value is stored as two half-width copies when bits 63..31 are all equal, and as one full word otherwise. A half-width entry therefore still reads correctly after every codeword of its lower half holds two errors.
- R4: Data bit b belongs to group (b/32)*8 + (b mod 8), and check bit k belongs to group k mod 16. A single flipped bit in any group's data or check cells is corrected on the output, and the correction flag is 1.
- R5: In a full-width entry, two flipped bits in any one group set the uncorrectable flag to 1 and clear the correction flag.
- R6: In a half-width entry, the output is the sign-extended copy. The lower copy is used if its groups are clean. Otherwise the upper copy is used if it is clean. Otherwise the copy without a double error is used, the lower copy first. The correction flag is 1 whenever either copy shows an error and a good copy exists.
- R7: In a half-width entry where both copies contain a double-error group, the uncorrectable flag is 1.
- R8: The two format bits are 00 for a full word and 11 for two copies. If they disagree, the read reports uncorrectable (1) and no correction (0).
- R9: The injection port XORs its three masks into the addressed entry at the clock edge. When a write to the same entry happens in the same cycle, the masks apply on top of the newly written contents.
- R10: A read of an undamaged entry returns exactly the value written, with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write enable |
| waddr | input | 6 | Write entry index |
| wdata | input | 64 | Write value |
| raddr0 | input | 6 | Read port 0 entry index |
| rdata0 | output | 64 | Read port 0 corrected value |
| rcorr0 | output | 1 | Read port 0 error repaired |
| ruerr0 | output | 1 | Read port 0 error not repairable |
| raddr1 | input | 6 | Read port 1 entry index |
| rdata1 | output | 64 | Read port 1 corrected value |
| rcorr1 | output | 1 | Read port 1 error repaired |
| ruerr1 | output | 1 | Read port 1 error not repairable |
| inj_en | input | 1 | Apply upset masks this cycle |
| inj_addr | input | 6 | Entry to upset |
| inj_dmask | input | 64 | Data cells to flip |
| inj_cmask | input | 64 | Check cells to flip |
| inj_fmask | input | 2 | Format cells to flip |

## Verification
The read path has no registers, so a wrong stored word, a misplaced check bit or a wrong format decision shows on the read port in the same cycle the entry is addressed. A wrong group mapping shows up as a false uncorrectable flag or as wrong data after a burst that the correct mapping would spread out. A wrong narrow decision shows up as a failure to survive a double error in one half. A wrong copy-selection order gives wrong data in the first read after damage to the lower copy.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

    localparam int DW   = 64;          // data word width
    localparam int HW   = DW / 2;      // half-width copy
    localparam int GW   = 4;           // data bits per codeword
    localparam int CW   = 4;           // check bits per codeword
    localparam int NGRP = DW / GW;     // codewords per word
    localparam int GPH  = NGRP / 2;    // codewords per half

    typedef struct packed {
        logic [GW-1:0] d;      // repaired data nibble
        logic          sgl;    // single error seen (repaired)
        logic          dbl;    // double error seen (not repairable)
    } grp_res_t;

    typedef enum logic [1:0] {
        SRC_FULL = 2'd0,
        SRC_LO   = 2'd1,
        SRC_HI   = 2'd2
    } src_e;

    localparam logic [1:0] FMT_FULL   = 2'b00;
    localparam logic [1:0] FMT_NARROW = 2'b11;

    // data bit i of group g: groups are spread within each half
    function automatic int dpos(input int g, input int i);
        return (g / GPH) * HW + (g % GPH) + GPH * i;
    endfunction

    // check bit j of group g: neighbouring cells belong to different groups
    function automatic int cpos(input int g, input int j);
        return j * NGRP + g;
    endfunction

    function automatic logic [CW-1:0] enc84(input logic [GW-1:0] d);
        logic p1, p2, p4, p0;
        p1 = d[0] ^ d[1] ^ d[3];
        p2 = d[0] ^ d[2] ^ d[3];
        p4 = d[1] ^ d[2] ^ d[3];
        p0 = (^d) ^ p1 ^ p2 ^ p4;
        return {p0, p4, p2, p1};
    endfunction

    function automatic grp_res_t dec84(input logic [GW-1:0] d, input logic [CW-1:0] c);
        grp_res_t r;
        logic [2:0] syn;
        logic       ov;
        syn[0] = c[0] ^ d[0] ^ d[1] ^ d[3];
        syn[1] = c[1] ^ d[0] ^ d[2] ^ d[3];
        syn[2] = c[2] ^ d[1] ^ d[2] ^ d[3];
        ov     = ^{c, d};
        r.d    = d;
        if (ov) begin
            case (syn)
                3'd3:    r.d[0] = ~d[0];
                3'd5:    r.d[1] = ~d[1];
                3'd6:    r.d[2] = ~d[2];
                3'd7:    r.d[3] = ~d[3];
                default: r.d    = d;
            endcase
        end
        r.sgl = ov;
        r.dbl = !ov && (syn != 3'd0);
        return r;
    endfunction

    function automatic logic [DW-1:0] enc_word(input logic [DW-1:0] w);
        logic [DW-1:0] ck;
        logic [GW-1:0] nib;
        logic [CW-1:0] c;
        ck = '0;
        for (int g = 0; g < NGRP; g++) begin
            for (int i = 0; i < GW; i++) nib[i] = w[dpos(g, i)];
            c = enc84(nib);
            for (int j = 0; j < CW; j++) ck[cpos(g, j)] = c[j];
        end
        return ck;
    endfunction

    function automatic logic fits_half(input logic [DW-1:0] w);
        return (&w[DW-1:HW-1]) | ~(|w[DW-1:HW-1]);
    endfunction

endpackage

// File: rtl/rfp_store.sv
module rfp_store
    import rfp_pkg::*;
#(
    parameter int NENT = 64,
    parameter int AW   = 6,
    parameter int NRD  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [DW-1:0] wchk,
    input  logic [1:0]    wfmt,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_addr,
    input  logic [DW-1:0] inj_dmask,
    input  logic [DW-1:0] inj_cmask,
    input  logic [1:0]    inj_fmask,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdat  [NRD],
    output logic [DW-1:0] rchk  [NRD],
    output logic [1:0]    rfmt  [NRD]
);

    logic [DW-1:0] dmem [NENT];
    logic [DW-1:0] cmem [NENT];
    logic [1:0]    fmem [NENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NENT; e++) begin
                dmem[e] <= '0;
                cmem[e] <= '0;
                fmem[e] <= FMT_FULL;
            end
        end else begin
            for (int e = 0; e < NENT; e++) begin
                dmem[e] <= ((we && waddr == AW'(e)) ? wdat : dmem[e])
                         ^ ((inj_en && inj_addr == AW'(e)) ? inj_dmask : '0);
                cmem[e] <= ((we && waddr == AW'(e)) ? wchk : cmem[e])
                         ^ ((inj_en && inj_addr == AW'(e)) ? inj_cmask : '0);
                fmem[e] <= ((we && waddr == AW'(e)) ? wfmt : fmem[e])
                         ^ ((inj_en && inj_addr == AW'(e)) ? inj_fmask : 2'b00);
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdat[p] = dmem[raddr[p]];
        assign rchk[p] = cmem[raddr[p]];
        assign rfmt[p] = fmem[raddr[p]];
    end

endmodule

// File: rtl/rfp_word_dec.sv
module rfp_word_dec
    import rfp_pkg::*;
(
    input  logic [DW-1:0]   data,
    input  logic [DW-1:0]   chk,
    output logic [DW-1:0]   fixed,
    output logic [NGRP-1:0] sgl,
    output logic [NGRP-1:0] dbl
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [GW-1:0] nib;
        logic [CW-1:0] cw;
        grp_res_t      res;
        for (genvar i = 0; i < GW; i++) begin : g_bit
            assign nib[i]             = data[dpos(g, i)];
            assign cw[i]              = chk[cpos(g, i)];
            assign fixed[dpos(g, i)]  = res.d[i];
        end
        assign res    = dec84(nib, cw);
        assign sgl[g] = res.sgl;
        assign dbl[g] = res.dbl;
    end

endmodule

// File: rtl/rfp_read_sel.sv
module rfp_read_sel
    import rfp_pkg::*;
(
    input  logic [DW-1:0]   fixed,
    input  logic [NGRP-1:0] sgl,
    input  logic [NGRP-1:0] dbl,
    input  logic [1:0]      fmt,
    output logic [DW-1:0]   data,
    output logic            corr,
    output logic            uerr
);

    logic lo_err, lo_bad, hi_err, hi_bad;
    src_e src;

    assign lo_err = |(sgl[GPH-1:0] | dbl[GPH-1:0]);
    assign lo_bad = |dbl[GPH-1:0];
    assign hi_err = |(sgl[NGRP-1:GPH] | dbl[NGRP-1:GPH]);
    assign hi_bad = |dbl[NGRP-1:GPH];

    always_comb begin
        src  = SRC_FULL;
        corr = 1'b0;
        uerr = 1'b0;
        case (fmt)
            FMT_FULL: begin
                uerr = |dbl;
                corr = (|sgl) && !uerr;
            end
            FMT_NARROW: begin
                if (!lo_err)                 src = SRC_LO;
                else if (!hi_err)            src = SRC_HI;
                else if (!lo_bad)            src = SRC_LO;
                else if (!hi_bad)            src = SRC_HI;
                else                         src = SRC_LO;
                uerr = lo_bad && hi_bad;
                corr = (lo_err || hi_err) && !uerr;
            end
            default: begin
                uerr = 1'b1;
            end
        endcase
    end

    always_comb begin
        case (src)
            SRC_LO:  data = {{HW{fixed[HW-1]}}, fixed[HW-1:0]};
            SRC_HI:  data = {{HW{fixed[DW-1]}}, fixed[DW-1:HW]};
            default: data = fixed;
        endcase
    end

endmodule

// File: rtl/rfp_regfile.sv
module rfp_regfile
    import rfp_pkg::*;
#(
    parameter int NENT = 64,
    localparam int AW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [63:0]   wdata,
    input  logic [AW-1:0] raddr0,
    output logic [63:0]   rdata0,
    output logic          rcorr0,
    output logic          ruerr0,
    input  logic [AW-1:0] raddr1,
    output logic [63:0]   rdata1,
    output logic          rcorr1,
    output logic          ruerr1,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_addr,
    input  logic [63:0]   inj_dmask,
    input  logic [63:0]   inj_cmask,
    input  logic [1:0]    inj_fmask
);

    localparam int NRD = 2;

    logic          narrow;
    logic [DW-1:0] st_dat, st_chk;
    logic [1:0]    st_fmt;

    assign narrow = fits_half(wdata);
    assign st_dat = narrow ? {wdata[HW-1:0], wdata[HW-1:0]} : wdata;
    assign st_chk = enc_word(st_dat);
    assign st_fmt = narrow ? FMT_NARROW : FMT_FULL;

    logic [AW-1:0] ra  [NRD];
    logic [DW-1:0] rd  [NRD];
    logic [DW-1:0] rc  [NRD];
    logic [1:0]    rf  [NRD];
    logic [DW-1:0] od  [NRD];
    logic          oc  [NRD];
    logic          ou  [NRD];

    assign ra[0] = raddr0;
    assign ra[1] = raddr1;

    rfp_store #(.NENT(NENT), .AW(AW), .NRD(NRD)) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (we),
        .waddr     (waddr),
        .wdat      (st_dat),
        .wchk      (st_chk),
        .wfmt      (st_fmt),
        .inj_en    (inj_en),
        .inj_addr  (inj_addr),
        .inj_dmask (inj_dmask),
        .inj_cmask (inj_cmask),
        .inj_fmask (inj_fmask),
        .raddr     (ra),
        .rdat      (rd),
        .rchk      (rc),
        .rfmt      (rf)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        logic [DW-1:0]   fixed;
        logic [NGRP-1:0] sgl, dbl;

        rfp_word_dec u_dec (
            .data  (rd[p]),
            .chk   (rc[p]),
            .fixed (fixed),
            .sgl   (sgl),
            .dbl   (dbl)
        );

        rfp_read_sel u_sel (
            .fixed (fixed),
            .sgl   (sgl),
            .dbl   (dbl),
            .fmt   (rf[p]),
            .data  (od[p]),
            .corr  (oc[p]),
            .uerr  (ou[p])
        );
    end

    assign rdata0 = od[0];
    assign rcorr0 = oc[0];
    assign ruerr0 = ou[0];
    assign rdata1 = od[1];
    assign rcorr1 = oc[1];
    assign ruerr1 = ou[1];

endmodule

// File: rtl/rfp_regfile_chk.sv
module rfp_regfile_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          we,
    input logic [AW-1:0] waddr,
    input logic [63:0]   wdata,
    input logic          inj_en,
    input logic [AW-1:0] raddr0,
    input logic [63:0]   rdata0,
    input logic          rcorr0,
    input logic          ruerr0,
    input logic [AW-1:0] raddr1,
    input logic [63:0]   rdata1,
    input logic          rcorr1,
    input logic          ruerr1
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata0 == 64'd0 && !rcorr0 && !ruerr0));

    // R10
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(inj_en) && !$past(rst) && raddr0 == $past(waddr))
        |-> (rdata0 == $past(wdata) && !rcorr0 && !ruerr0));

    // R2
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(we) && !$past(inj_en) && $stable(raddr0))
        |-> $stable(rdata0));

    // R2
    ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (raddr0 == raddr1)
        |-> (rdata0 == rdata1 && rcorr0 == rcorr1 && ruerr0 == ruerr1));

    // R5
    flag_excl0_chk: assert property (@(posedge clk) disable iff (rst)
        !(rcorr0 && ruerr0));

    // R7
    flag_excl1_chk: assert property (@(posedge clk) disable iff (rst)
        !(rcorr1 && ruerr1));

endmodule

bind rfp_regfile rfp_regfile_chk #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .we     (we),
    .waddr  (waddr),
    .wdata  (wdata),
    .inj_en (inj_en),
    .raddr0 (raddr0),
    .rdata0 (rdata0),
    .rcorr0 (rcorr0),
    .ruerr0 (ruerr0),
    .raddr1 (raddr1),
    .rdata1 (rdata1),
    .rcorr1 (rcorr1),
    .ruerr1 (ruerr1)
);

// File: tb/tb_rfp_regfile.sv
`timescale 1ns/1ps
module tb_rfp_regfile;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic [5:0]  waddr;
    logic [63:0] wdata;
    logic [5:0]  raddr0, raddr1;
    logic [63:0] rdata0, rdata1;
    logic        rcorr0, ruerr0, rcorr1, ruerr1;
    logic        inj_en;
    logic [5:0]  inj_addr;
    logic [63:0] inj_dmask, inj_cmask;
    logic [1:0]  inj_fmask;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    logic [63:0] m_val [N];
    bit          m_nar [N];
    logic [63:0] m_dm  [N];
    logic [63:0] m_cm  [N];
    logic [1:0]  m_fm  [N];

    always #2.5 clk = ~clk;

    rfp_regfile dut (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr0(raddr0), .rdata0(rdata0), .rcorr0(rcorr0), .ruerr0(ruerr0),
        .raddr1(raddr1), .rdata1(rdata1), .rcorr1(rcorr1), .ruerr1(ruerr1),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_dmask(inj_dmask),
        .inj_cmask(inj_cmask), .inj_fmask(inj_fmask)
    );

    function automatic int grp_d(input int b);
        return (b / 32) * 8 + (b % 8);
    endfunction

    function automatic int grp_c(input int b);
        return b % 16;
    endfunction

    function automatic int max_hits(input logic [63:0] dm, input logic [63:0] cm);
        int cnt [16];
        int mx;
        for (int g = 0; g < 16; g++) cnt[g] = 0;
        for (int b = 0; b < 64; b++) begin
            if (dm[b]) cnt[grp_d(b)]++;
            if (cm[b]) cnt[grp_c(b)]++;
        end
        mx = 0;
        for (int g = 0; g < 16; g++) if (cnt[g] > mx) mx = cnt[g];
        return mx;
    endfunction

    function automatic bit is_narrow(input logic [63:0] v);
        return (v[63:31] == '0) || (v[63:31] == '1);
    endfunction

    // expected read of entry a; known = damage within code limits, dk = data meaningful
    task automatic expect_rd(input int a, output logic [63:0] ed, output logic ec,
                             output logic eu, output bit known, output bit dk);
        int cnt [16];
        bit lo_err, lo_bad, hi_err, hi_bad, any1, any2;
        for (int g = 0; g < 16; g++) cnt[g] = 0;
        for (int b = 0; b < 64; b++) begin
            if (m_dm[a][b]) cnt[grp_d(b)]++;
            if (m_cm[a][b]) cnt[grp_c(b)]++;
        end
        known = 1; lo_err = 0; lo_bad = 0; hi_err = 0; hi_bad = 0; any1 = 0; any2 = 0;
        for (int g = 0; g < 16; g++) begin
            if (cnt[g] > 2) known = 0;
            if (cnt[g] == 1) any1 = 1;
            if (cnt[g] == 2) any2 = 1;
            if (g < 8) begin
                if (cnt[g] > 0) lo_err = 1;
                if (cnt[g] == 2) lo_bad = 1;
            end else begin
                if (cnt[g] > 0) hi_err = 1;
                if (cnt[g] == 2) hi_bad = 1;
            end
        end
        ed = m_val[a];
        if (m_fm[a] != 2'b00) begin
            eu = 1; ec = 0; dk = 0;
        end else if (!m_nar[a]) begin
            eu = any2; ec = any1 && !any2; dk = !any2;
        end else begin
            eu = lo_bad && hi_bad; ec = (lo_err || hi_err) && !eu; dk = !eu;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_port(input int p, input int a, input string req);
        logic [63:0] ed, ad;
        logic ec, eu, ac, au;
        bit known, dk;
        expect_rd(a, ed, ec, eu, known, dk);
        if (p == 0) begin ad = rdata0; ac = rcorr0; au = ruerr0; end
        else        begin ad = rdata1; ac = rcorr1; au = ruerr1; end
        if (known) begin
            chk(au === eu, req, "uerr", {63'd0, au}, {63'd0, eu});
            chk(ac === ec, req, "corr", {63'd0, ac}, {63'd0, ec});
            if (dk) chk(ad === ed, req, "data", ad, ed);
        end
    endtask

    task automatic rd(input int a, input int b, input string req);
        @(negedge clk);
        raddr0 = 6'(a); raddr1 = 6'(b);
        #1;
        check_port(0, a, req);
        check_port(1, b, req);
    endtask

    task automatic wr(input int a, input logic [63:0] v);
        @(negedge clk);
        we = 1; waddr = 6'(a); wdata = v;
        @(negedge clk);
        we = 0;
        m_val[a] = v; m_nar[a] = is_narrow(v);
        m_dm[a] = '0; m_cm[a] = '0; m_fm[a] = 2'b00;
    endtask

    task automatic inj(input int a, input logic [63:0] dm, input logic [63:0] cm,
                       input logic [1:0] fm);
        @(negedge clk);
        inj_en = 1; inj_addr = 6'(a); inj_dmask = dm; inj_cmask = cm; inj_fmask = fm;
        @(negedge clk);
        inj_en = 0; inj_dmask = '0; inj_cmask = '0; inj_fmask = 2'b00;
        m_dm[a] ^= dm; m_cm[a] ^= cm; m_fm[a] ^= fm;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd8191));
        rst = 1; we = 0; waddr = '0; wdata = '0; raddr0 = '0; raddr1 = '0;
        inj_en = 0; inj_addr = '0; inj_dmask = '0; inj_cmask = '0; inj_fmask = '0;
        for (int e = 0; e < N; e++) begin
            m_val[e] = '0; m_nar[e] = 0; m_dm[e] = '0; m_cm[e] = '0; m_fm[e] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;

        // R1 reset state
        rd(0, 63, "R1");
        rd(17, 42, "R1");

        // R10 clean write/read, both widths
        wr(1, 64'h1234_5678_9abc_def0);
        wr(2, 64'hffff_ffff_8000_0001);
        rd(1, 2, "R10");

        // R2 read during write returns old contents, then new
        @(negedge clk);
        we = 1; waddr = 6'd1; wdata = 64'h0000_0000_0000_0042; raddr0 = 6'd1; raddr1 = 6'd2;
        #1;
        check_port(0, 1, "R2");
        @(negedge clk);
        we = 0;
        m_val[1] = 64'h42; m_nar[1] = 1;
        #1;
        check_port(0, 1, "R2");
        check_port(1, 2, "R2");

        // R3 narrow value survives doubles in every lower group
        wr(3, 64'hffff_ffff_8000_0000);
        inj(3, 64'h0000_0000_0000_ffff, '0, 2'b00);
        rd(3, 3, "R3");
        // R3/R5 same pattern on a value that is not narrow
        wr(4, 64'h0000_0000_8000_0000);
        inj(4, 64'h0000_0000_0000_ffff, '0, 2'b00);
        rd(4, 4, "R5");

        // R4 single data flip and a 16-cell check burst (one per group)
        wr(5, 64'hdead_beef_0bad_f00d);
        inj(5, 64'h0000_0400_0000_0000, '0, 2'b00);
        rd(5, 5, "R4");
        wr(6, 64'hcafe_0000_1111_2222);
        inj(6, '0, 64'h0000_0000_ffff_0000, 2'b00);
        rd(6, 6, "R4");

        // R6 lower copy single, upper copy double -> lower used
        wr(7, 64'hffff_ffff_f000_0123);
        inj(7, 64'h0000_0101_0000_0004, '0, 2'b00);
        rd(7, 7, "R6");
        // R6 lower copy single, upper clean -> upper used
        wr(8, 64'h0000_0000_7654_3210);
        inj(8, 64'h0000_0000_0000_0100, '0, 2'b00);
        rd(8, 8, "R6");

        // R7 both copies with a double
        wr(9, 64'h0000_0000_0000_5555);
        inj(9, 64'h0000_0101_0000_0101, '0, 2'b00);
        rd(9, 9, "R7");

        // R8 one format cell upset
        wr(10, 64'h0000_0000_0000_0007);
        inj(10, '0, '0, 2'b01);
        rd(10, 10, "R8");
        wr(11, 64'h8765_4321_0fed_cba9);
        inj(11, '0, '0, 2'b10);
        rd(11, 11, "R8");

        // R9 write and upset in the same cycle
        @(negedge clk);
        we = 1; waddr = 6'd12; wdata = 64'h0f0f_0f0f_0f0f_0f0f;
        inj_en = 1; inj_addr = 6'd12; inj_dmask = 64'h20; inj_cmask = '0; inj_fmask = '0;
        @(negedge clk);
        we = 0; inj_en = 0; inj_dmask = '0;
        m_val[12] = 64'h0f0f_0f0f_0f0f_0f0f; m_nar[12] = 0;
        m_dm[12] = 64'h20; m_cm[12] = '0; m_fm[12] = '0;
        rd(12, 12, "R9");

        // random campaign
        for (int t = 0; t < 400; t++) begin
            int a, kind, other;
            logic [63:0] v, dm, cm;
            logic [1:0] fm;
            a = $urandom_range(N - 1);
            v = rnd64();
            if ($urandom_range(1)) v = {{32{v[31]}}, v[31:0]};
            wr(a, v);
            kind = $urandom_range(4);
            dm = '0; cm = '0; fm = 2'b00;
            case (kind)
                1: begin
                    if ($urandom_range(1)) dm[$urandom_range(63)] = 1'b1;
                    else                   cm[$urandom_range(63)] = 1'b1;
                end
                2: begin
                    int s, len;
                    bit side;
                    len  = $urandom_range(16, 2);
                    s    = $urandom_range(64 - len);
                    side = 1'($urandom_range(1));
                    for (int k = 0; k < len; k++) begin
                        if (side) dm[s + k] = 1'b1;
                        else      cm[s + k] = 1'b1;
                    end
                end
                3: begin
                    do begin
                        int nb;
                        dm = '0; cm = '0;
                        nb = $urandom_range(4, 2);
                        for (int k = 0; k < nb; k++) begin
                            if ($urandom_range(1)) dm[$urandom_range(63)] = 1'b1;
                            else                   cm[$urandom_range(63)] = 1'b1;
                        end
                    end while (max_hits(dm, cm) > 2);
                end
                4: fm = 2'($urandom_range(2, 1));
                default: ;
            endcase
            if (kind != 0) inj(a, dm, cm, fm);
            other = $urandom_range(N - 1);
            case (kind)
                0: rd(a, other, "R10");
                1: rd(a, other, "R4");
                4: rd(a, other, "R8");
                default: rd(a, other, m_nar[a] ? "R6" : "R5");
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule